// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs an 8-bit accumulator that holds two packed BCD digits after a plain binary add or subtract. It receives the byte left by that arithmetic, together with the auxiliary-carry and carry flags that the arithmetic produced. It returns a byte that is a valid BCD pair, plus a full set of status flags. A single select input picks the repair direction: add-adjust or subtract-adjust.

The repair has two fix-ups. The first acts on the low digit and the second on the high digit. Both decisions look only at the original byte and the incoming flags. The second fix-up is applied to the byte that the first fix-up produced. The result is computed combinationally and captured in an output register, so every input set yields its result one clock later. The unit is fed every cycle and has no other state. The upper accumulator byte and the arithmetic that comes before the unit are not part of it.

Top module: `bcd_adjust_unit`

## Requirements
- R1: The low fix-up applies when the original byte's low nibble (bits 3:0) is above 9 or `aux_in` is 1. When it applies, it adds 6 with `sub_mode`=0 and subtracts 6 with `sub_mode`=1, modulo 256.
- R2: `aux_out` is 1 exactly when the low fix-up applies. Otherwise it is 0.
- R3: With `sub_mode`=0 and the low fix-up applied, the interim carry is 1 when the original byte is above 0xF9 or `carry_in` is 1. Otherwise it is 0.
- R4: With `sub_mode`=1 and the low fix-up applied, the interim carry is 1 when the original byte is below 0x06 or `carry_in` is 1. Otherwise it is 0.
- R5: The high fix-up applies when the original byte is above 0x99 or `carry_in` is 1. It adds 0x60 (`sub_mode`=0) or subtracts 0x60 (`sub_mode`=1), modulo 256, to the byte that leaves the low fix-up, and it forces `carry_out` to 1. When the high fix-up does not apply, `carry_out` equals the interim carry, which is 0 if the low fix-up did not apply.
- R6: `sign_out` is bit 7 of `acc_out`. `zero_out` is 1 when `acc_out` is 0x00. `parity_out` is 1 when `acc_out` has an even number of set bits.
- R7: `ovf_out` is always 0.
- R8: All outputs are registered and show the result for the inputs of the previous rising clock edge. While `rst_n` is low, `acc_out`=0x00, `zero_out`=1, `parity_out`=1, and every other flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_mode | input | 1 | 0 = add-adjust, 1 = subtract-adjust |
| acc_in | input | 8 | Accumulator byte after the binary operation |
| aux_in | input | 1 | Incoming auxiliary-carry flag |
| carry_in | input | 1 | Incoming carry flag |
| acc_out | output | 8 | Corrected byte |
| sign_out | output | 1 | Sign flag of the result |
| zero_out | output | 1 | Zero flag of the result |
| parity_out | output | 1 | Even-parity flag of the result |
| ovf_out | output | 1 | Overflow flag, held at 0 |
| aux_out | output | 1 | Resulting auxiliary-carry flag |
| carry_out | output | 1 | Resulting carry flag |

## Verification
The unit holds no state beyond its output register. Any fault in the fix-up logic therefore appears at the ports exactly one clock after the input vector that exposes it, and it never builds up over later cycles. The risky cases are the boundaries:
- low nibbles 9 and 0xA;
- bytes around 0x99/0x9A and 0xF9/0xFA in add mode;
- bytes around 0x05/0x06 in subtract mode.

A wrong interim carry, or a high fix-up that uses the original byte instead of the adjusted one, shows up only for some of these bytes. For that reason, every byte is swept under every flag combination in both modes.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int DIGIT_MAX = 9;
    localparam logic [BYTE_W-1:0] LOW_STEP  = 8'h06;
    localparam logic [BYTE_W-1:0] HIGH_STEP = 8'h60;
    localparam logic [BYTE_W-1:0] HIGH_LIM  = 8'h99;
    localparam logic [BYTE_W-1:0] ADD_WRAP_LIM = 8'hF9;
    localparam logic [BYTE_W-1:0] SUB_WRAP_LIM = 8'h06;

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic              sf;
        logic              zf;
        logic              pf;
        logic              of;
        logic              af;
        logic              cf;
    } adj_result_t;
endpackage

// File: rtl/bcd_low_fix.sv
module bcd_low_fix
    import bcd_adj_pkg::*;
(
    input  logic              sub_mode,
    input  logic [BYTE_W-1:0] acc_orig,
    input  logic              aux_in,
    input  logic              carry_in,
    output logic [BYTE_W-1:0] acc_mid,
    output logic              aux_mid,
    output logic              carry_mid
);
    logic apply;

    always_comb begin
        apply     = (acc_orig[NIB_W-1:0] > NIB_W'(DIGIT_MAX)) || aux_in;
        acc_mid   = acc_orig;
        aux_mid   = 1'b0;
        carry_mid = 1'b0;
        if (apply) begin
            aux_mid = 1'b1;
            if (sub_mode) begin
                carry_mid = (acc_orig < SUB_WRAP_LIM) || carry_in;
                acc_mid   = acc_orig - LOW_STEP;
            end else begin
                carry_mid = (acc_orig > ADD_WRAP_LIM) || carry_in;
                acc_mid   = acc_orig + LOW_STEP;
            end
        end
    end
endmodule

// File: rtl/bcd_high_fix.sv
module bcd_high_fix
    import bcd_adj_pkg::*;
(
    input  logic              sub_mode,
    input  logic [BYTE_W-1:0] acc_orig,
    input  logic [BYTE_W-1:0] acc_mid,
    input  logic              carry_in,
    input  logic              carry_mid,
    output logic [BYTE_W-1:0] acc_fin,
    output logic              carry_fin
);
    logic apply;

    always_comb begin
        apply     = (acc_orig > HIGH_LIM) || carry_in;
        acc_fin   = acc_mid;
        carry_fin = carry_mid;
        if (apply) begin
            carry_fin = 1'b1;
            acc_fin   = sub_mode ? (acc_mid - HIGH_STEP) : (acc_mid + HIGH_STEP);
        end
    end
endmodule

// File: rtl/bcd_status_flags.sv
module bcd_status_flags
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] value,
    output logic              sign,
    output logic              zero,
    output logic              parity
);
    always_comb begin
        sign   = value[BYTE_W-1];
        zero   = (value == '0);
        parity = ~(^value);
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_mode,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic              aux_in,
    input  logic              carry_in,
    output logic [BYTE_W-1:0] acc_out,
    output logic              sign_out,
    output logic              zero_out,
    output logic              parity_out,
    output logic              ovf_out,
    output logic              aux_out,
    output logic              carry_out
);
    localparam adj_result_t RESET_VAL = '{acc: '0, sf: 1'b0, zf: 1'b1,
                                          pf: 1'b1, of: 1'b0, af: 1'b0, cf: 1'b0};

    logic [BYTE_W-1:0] acc_mid, acc_fin;
    logic              aux_mid, carry_mid, carry_fin;
    logic              sf_w, zf_w, pf_w;
    adj_result_t       res_d, res_q;

    bcd_low_fix u_low (
        .sub_mode (sub_mode),
        .acc_orig (acc_in),
        .aux_in   (aux_in),
        .carry_in (carry_in),
        .acc_mid  (acc_mid),
        .aux_mid  (aux_mid),
        .carry_mid(carry_mid)
    );

    bcd_high_fix u_high (
        .sub_mode (sub_mode),
        .acc_orig (acc_in),
        .acc_mid  (acc_mid),
        .carry_in (carry_in),
        .carry_mid(carry_mid),
        .acc_fin  (acc_fin),
        .carry_fin(carry_fin)
    );

    bcd_status_flags u_flags (
        .value (acc_fin),
        .sign  (sf_w),
        .zero  (zf_w),
        .parity(pf_w)
    );

    always_comb begin
        res_d.acc = acc_fin;
        res_d.sf  = sf_w;
        res_d.zf  = zf_w;
        res_d.pf  = pf_w;
        res_d.of  = 1'b0;
        res_d.af  = aux_mid;
        res_d.cf  = carry_fin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= RESET_VAL;
        else        res_q <= res_d;
    end

    assign acc_out    = res_q.acc;
    assign sign_out   = res_q.sf;
    assign zero_out   = res_q.zf;
    assign parity_out = res_q.pf;
    assign ovf_out    = res_q.of;
    assign aux_out    = res_q.af;
    assign carry_out  = res_q.cf;
endmodule

// File: rtl/bcd_adjust_checker.sv
module bcd_adjust_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] acc_in,
    input logic       aux_in,
    input logic       carry_in,
    input logic [7:0] acc_out,
    input logic       sign_out,
    input logic       zero_out,
    input logic       parity_out,
    input logic       ovf_out,
    input logic       aux_out,
    input logic       carry_out
);
    // R2: an incoming auxiliary carry always triggers the low fix-up
    a_r2_aux_forces: assert property (@(posedge clk) disable iff (!rst_n)
        aux_in |=> aux_out);
    // R2: no trigger means the auxiliary carry is cleared
    a_r2_aux_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_in && acc_in[3:0] <= 4'd9) |=> !aux_out);
    // R5: an incoming carry always forces the carry out
    a_r5_carry_forces: assert property (@(posedge clk) disable iff (!rst_n)
        carry_in |=> carry_out);
    // R6: status flags agree with the registered byte
    a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
        sign_out == acc_out[7]);
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_out == (acc_out == 8'h00));
    a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
        parity_out == ($countones(acc_out) % 2 == 0));
    // R7
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_out);
endmodule

bind bcd_adjust_unit bcd_adjust_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_in    (acc_in),
    .aux_in    (aux_in),
    .carry_in  (carry_in),
    .acc_out   (acc_out),
    .sign_out  (sign_out),
    .zero_out  (zero_out),
    .parity_out(parity_out),
    .ovf_out   (ovf_out),
    .aux_out   (aux_out),
    .carry_out (carry_out)
);

// File: tb/bcd_adjust_unit_bench.sv
module bcd_adjust_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_mode = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic       aux_in = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] acc_out;
    logic       sign_out, zero_out, parity_out, ovf_out, aux_out, carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int acc; int sf; int zf; int pf; int af; int cf; int sub;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_adjust_unit u_bcd_adjust_unit (
        .clk(clk), .rst_n(rst_n), .sub_mode(sub_mode), .acc_in(acc_in),
        .aux_in(aux_in), .carry_in(carry_in), .acc_out(acc_out),
        .sign_out(sign_out), .zero_out(zero_out), .parity_out(parity_out),
        .ovf_out(ovf_out), .aux_out(aux_out), .carry_out(carry_out)
    );

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input int a, input int af, input int cf, input int sub);
        exp_t e;
        int r = a, raf = 0, rcf = 0, ones = 0;
        if ((a % 16) > 9 || af != 0) begin
            raf = 1;
            if (sub != 0) begin rcf = (a < 6 || cf != 0) ? 1 : 0; r = (r - 6 + 256) % 256; end
            else          begin rcf = (a > 249 || cf != 0) ? 1 : 0; r = (r + 6) % 256; end
        end
        if (a > 153 || cf != 0) begin
            rcf = 1;
            r = (sub != 0) ? (r - 96 + 256) % 256 : (r + 96) % 256;
        end
        for (int b = 0; b < 8; b++) ones += (r >> b) & 1;
        e.acc = r; e.sf = (r >= 128) ? 1 : 0; e.zf = (r == 0) ? 1 : 0;
        e.pf = (ones % 2 == 0) ? 1 : 0; e.af = raf; e.cf = rcf; e.sub = sub;
        return e;
    endfunction

    task automatic compare_out();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        check("R5", "acc_out", int'(acc_out), e.acc);
        check("R2", "aux_out", int'(aux_out), e.af);
        check((e.sub != 0) ? "R4" : "R3", "carry_out", int'(carry_out), e.cf);
        check("R6", "sign_out", int'(sign_out), e.sf);
        check("R6", "zero_out", int'(zero_out), e.zf);
        check("R6", "parity_out", int'(parity_out), e.pf);
        check("R7", "ovf_out", int'(ovf_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "reset acc_out", int'(acc_out), 0);
        check("R8", "reset zero_out", int'(zero_out), 1);
        check("R8", "reset parity_out", int'(parity_out), 1);
        check("R8", "reset flags", int'({sign_out, ovf_out, aux_out, carry_out}), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 4; f++) begin
                for (int v = 0; v < 256; v++) begin
                    compare_out();
                    sub_mode = m[0];
                    aux_in   = f[0];
                    carry_in = f[1];
                    acc_in   = v[7:0];
                    exp_q.push_back(model(v, f & 1, (f >> 1) & 1, m));
                    @(negedge clk);
                end
            end
        end
        compare_out();
        // R1 / R8: spot checks of latency on known vectors (0x0A add -> 0x10; 0x00 sub with AF -> 0xFA)
        sub_mode = 1'b0; aux_in = 1'b0; carry_in = 1'b0; acc_in = 8'h0A;
        @(negedge clk);
        check("R1", "0x0A add-adjust", int'(acc_out), 'h10);
        sub_mode = 1'b1; aux_in = 1'b1; acc_in = 8'h00;
        @(negedge clk);
        check("R1", "0x00 sub-adjust with aux", int'(acc_out), 'hFA);
        check("R4", "0x00 sub-adjust carry", int'(carry_out), 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule